// File: doc/BRIEF.md
# Serial Sampling Converter Device Model

This block behaves, at its pins, like a 16-clock serial analog-to-digital converter that a host reads through a chip-select line and a serial clock. It works in a single system clock domain: the host's active-low chip-select and serial clock are brought in through synchronisers, and their edges are found as one-cycle pulses. A parallel sample word stands in for the analog input. No conversion clock exists apart from the host's serial clock, so the serial clock alone paces both the conversion progress and the bit transfer.

When chip-select falls, the block captures the sample word and builds a 16-slot frame. It enables its data output, drives the first slot and reports "hold" on its track/hold status. Each later serial-clock falling edge moves the output to the next slot. The output is released at the sixteenth falling edge, or at once if chip-select rises early. The status goes back to "track" on the first serial-clock rising edge after thirteen falling edges. The resolution is chosen at run time: 12, 10 or 8 data bits. The high-impedance state is modelled as a data line plus an output-enable line.

Top module: `adcif_top`

## Requirements
- R1: After reset, `sdata_oe` is 0, `sdata` is 0 and `track` is 1.
- R2: A chip-select falling edge enables the output (`sdata_oe`=1), drives the first frame slot, a 0, and sets `track` to 0 (hold).
- R3: The frame is 16 slots, sent MSB first: four zeros, then the data bits MSB first, then zeros to fill 16 slots. `res_sel` 2'b00 (or 2'b11) selects 12 bits `sample[11:0]`, 2'b01 selects 10 bits `sample[9:0]` followed by 2 zeros, and 2'b10 selects 8 bits `sample[7:0]` followed by 4 zeros.
- R4: After the k-th serial-clock falling edge of a frame (k = 1..15), `sdata` shows frame slot k, where slot 0 is the one driven at chip-select fall.
- R5: The sixteenth serial-clock falling edge of a frame sets `sdata_oe` to 0.
- R6: `track` returns to 1 on the first serial-clock rising edge after 13 falling edges of the frame, and not before.
- R7: A chip-select rise during a frame sets `sdata_oe` to 0 and `track` to 1 at once. The next chip-select fall starts a fresh frame from slot 0.
- R8: The frame content is fixed at chip-select fall. Changes on `sample` or `res_sel` during the frame do not alter it.
- R9: Serial-clock edges while chip-select is high, or after the frame has ended, leave `sdata_oe` at 0 and `sdata` at 0.
- R10: While `sdata_oe` is 0, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the host lines are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip-select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| res_sel | input | 2 | Resolution: 00 or 11 = 12 bits, 01 = 10 bits, 10 = 8 bits |
| sample | input | 12 | Parallel sample word standing in for the analog input |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Data output enable; 0 models high impedance |
| track | output | 1 | 1 = tracking, 0 = holding |

## Verification
On every cycle, the assertions check how the output enable, the data line, the track status and the edge counter relate to each other. The enable only turns on at a chip-select fall, and it starts in hold with a zero on the line. A chip-select rise always releases the line, the line is quiet while released, and the counter never passes sixteen. Frame content under each resolution, the exact falling edge that releases the line, the rising edge on which tracking resumes, and whether the captured word stays fixed while the sample input changes all depend on the whole stimulus sequence. The bench's sweeps over resolutions and sample patterns show these.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  typedef enum logic [1:0] {
    RES_12  = 2'b00,
    RES_10  = 2'b01,
    RES_8   = 2'b10,
    RES_ALT = 2'b11
  } res_e;
endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int STAGES   = 2,
  parameter bit INIT_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= INIT_VAL;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= INIT_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT_VAL;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adcif_framer.sv
module adcif_framer
  import adcif_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FRAME_W  = 16,
  parameter int LEAD_Z   = 4
) (
  input  logic [1:0]          res_sel,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [FRAME_W-1:0]  frame
);
  localparam int PAD = FRAME_W - LEAD_Z - SAMPLE_W;

  logic [SAMPLE_W-1:0] body;
  int unsigned         drop;

  always_comb begin
    unique case (res_e'(res_sel))
      RES_10:  drop = 2;
      RES_8:   drop = 4;
      default: drop = 0;
    endcase
    body  = (sample << drop);
    frame = FRAME_W'(body) << PAD;
  end
endmodule

// File: rtl/adcif_ctrl.sv
module adcif_ctrl #(
  parameter int FRAME_W     = 16,
  parameter int TRACK_AFTER = 13,
  parameter int CNT_W       = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_fall,
  input  logic               sclk_rise,
  input  logic [FRAME_W-1:0] frame,
  output logic               sdata,
  output logic               sdata_oe,
  output logic               track,
  output logic [CNT_W-1:0]   fall_cnt
);
  logic               active_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_nx;

  assign cnt_nx = fall_cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      fall_cnt <= '0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      track    <= 1'b1;
    end else if (cs_fall) begin
      active_q <= 1'b1;
      shreg_q  <= frame;
      fall_cnt <= '0;
      sdata    <= frame[FRAME_W-1];
      sdata_oe <= 1'b1;
      track    <= 1'b0;
    end else if (cs_rise) begin
      active_q <= 1'b0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      track    <= 1'b1;
    end else if (active_q) begin
      if (sclk_fall) begin
        fall_cnt <= cnt_nx;
        if (cnt_nx == CNT_W'(FRAME_W)) begin
          active_q <= 1'b0;
          sdata    <= 1'b0;
          sdata_oe <= 1'b0;
        end else begin
          shreg_q <= shreg_q << 1;
          sdata   <= shreg_q[FRAME_W-2];
        end
      end
      if (sclk_rise && fall_cnt >= CNT_W'(TRACK_AFTER)) track <= 1'b1;
    end
  end
endmodule

// File: rtl/adcif_top.sv
module adcif_top #(
  parameter int SAMPLE_W    = 12,
  parameter int FRAME_W     = 16,
  parameter int LEAD_Z      = 4,
  parameter int TRACK_AFTER = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [1:0]          res_sel,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata,
  output logic                sdata_oe,
  output logic                track
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic cs_lvl, cs_up, cs_dn;
  logic sc_lvl, sc_up, sc_dn;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   fall_cnt;

  adcif_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n),
    .level(cs_lvl), .rise(cs_up), .fall(cs_dn)
  );

  adcif_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .din(sclk),
    .level(sc_lvl), .rise(sc_up), .fall(sc_dn)
  );

  adcif_framer #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W), .LEAD_Z(LEAD_Z)) u_framer (
    .res_sel(res_sel), .sample(sample), .frame(frame)
  );

  adcif_ctrl #(.FRAME_W(FRAME_W), .TRACK_AFTER(TRACK_AFTER), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_fall(cs_dn), .cs_rise(cs_up),
    .sclk_fall(sc_dn), .sclk_rise(sc_up),
    .frame(frame),
    .sdata(sdata), .sdata_oe(sdata_oe), .track(track),
    .fall_cnt(fall_cnt)
  );

  logic unused_lvl;
  assign unused_lvl = cs_lvl ^ sc_lvl;
endmodule

// File: rtl/adcif_checker.sv
module adcif_checker #(
  parameter int CNT_W   = 5,
  parameter int FRAME_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             track,
  input logic [CNT_W-1:0] fall_cnt
);
  AST_OE_ON_CS_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) |-> $past(cs_fall));                       // R2
  AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) |-> (!track && !sdata));                   // R2
  AST_RELEASE_ON_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cs_fall) |=> (!sdata_oe && track));           // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata);                                     // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fall_cnt <= CNT_W'(FRAME_W));                              // R5
  AST_HOLD_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(track) |-> sdata_oe);                                // R6
endmodule

bind adcif_top adcif_checker #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .cs_fall(cs_dn), .cs_rise(cs_up),
  .sdata(sdata), .sdata_oe(sdata_oe), .track(track), .fall_cnt(fall_cnt)
);

// File: tb/tb_adcif_top.sv
`timescale 1ns/1ps
module tb_adcif_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n;
  logic        sclk;
  logic [1:0]  res_sel;
  logic [11:0] sample;
  logic        sdata, sdata_oe, track;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  localparam int SETTLE = 10;

  always #2.5 clk = ~clk;

  adcif_top dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .res_sel(res_sel), .sample(sample),
    .sdata(sdata), .sdata_oe(sdata_oe), .track(track)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_frame(input logic [1:0] rs, input logic [11:0] s);
    case (rs)
      2'b01:   return {4'b0, s[9:0], 2'b0};
      2'b10:   return {4'b0, s[7:0], 4'b0};
      default: return {4'b0, s};
    endcase
  endfunction

  // full 16-clock frame; sample/res_sel scrambled after capture (R8)
  task automatic run_frame(input logic [1:0] rs, input logic [11:0] s);
    logic [15:0] f;
    f = exp_frame(rs, s);
    res_sel = rs; sample = s;
    @(negedge clk); cs_n = 1'b0; settle();
    chk(sdata_oe == 1'b1, "R2 oe", sdata_oe, 1);
    chk(track == 1'b0, "R2 hold", track, 0);
    chk(sdata == f[15], "R2 slot0", sdata, f[15]);
    sample = ~s; res_sel = rs + 2'd1;   // R8 stimulus
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; settle();
      if (k < 16) begin
        chk(sdata_oe == 1'b1, "R4 oe", sdata_oe, 1);
        chk(sdata == f[15-k], "R3 R4 R8 bit", sdata, f[15-k]);
      end else begin
        chk(sdata_oe == 1'b0, "R5 release", sdata_oe, 0);
        chk(sdata == 1'b0, "R10 quiet", sdata, 0);
      end
      sclk = 1'b1; settle();
      chk(track == (k >= 13), "R6 track", track, int'(k >= 13));
    end
    cs_n = 1'b1; settle();
    chk(!sdata_oe && track, "R9 idle", sdata_oe, 0);
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; res_sel = 2'b00; sample = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sdata_oe == 1'b0, "R1 oe", sdata_oe, 0);
    chk(sdata == 1'b0, "R1 sdata", sdata, 0);
    chk(track == 1'b1, "R1 track", track, 1);

    for (int m = 0; m < 4; m++) begin
      run_frame(2'(m), 12'hFFF);
      run_frame(2'(m), 12'h000);
      run_frame(2'(m), 12'hA5C);
      run_frame(2'(m), 12'h801);
      for (int p = 0; p < 12; p++) run_frame(2'(m), 12'(1 << p));
    end

    // R9: sclk activity with chip-select high
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b0; settle();
      chk(!sdata_oe && !sdata, "R9 cs high", sdata_oe, 0);
      sclk = 1'b1; settle();
    end

    // R7: abort mid-frame after 5 falls, then extra edges, then fresh frame
    res_sel = 2'b00; sample = 12'h9F3;
    cs_n = 1'b0; settle();
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; settle(); sclk = 1'b1; settle();
    end
    chk(sdata_oe == 1'b1, "R7 pre-abort oe", sdata_oe, 1);
    cs_n = 1'b1; settle();
    chk(sdata_oe == 1'b0, "R7 abort oe", sdata_oe, 0);
    chk(track == 1'b1, "R7 abort track", track, 1);
    chk(sdata == 1'b0, "R10 after abort", sdata, 0);
    sclk = 1'b0; settle();
    chk(!sdata_oe, "R9 after abort", sdata_oe, 0);
    sclk = 1'b1; settle();
    run_frame(2'b10, 12'h3C7);   // R7 fresh frame from slot 0

    // R9: edges after frame end but cs still low
    cs_n = 1'b0; settle();
    for (int k = 0; k < 16; k++) begin
      sclk = 1'b0; settle(); sclk = 1'b1; settle();
    end
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b0; settle();
      chk(!sdata_oe && !sdata, "R9 after end", sdata_oe, 0);
      sclk = 1'b1; settle();
    end
    cs_n = 1'b1; settle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule